// File: doc/BRIEF.md
# Serial-Link Program Loader (Host Side)

This engine sits on the host end of a narrow serial link to a 32-bit target. It loads a short program into the target and starts it. On a `start` pulse it reads one word from the target's boot memory and compares it with `boot_expect`. It then writes each program word into scratchpad memory and reads it straight back to confirm it. At the end it writes the value 1 to the target's software-interrupt register, which releases the target's boot loop so that it jumps into the scratchpad. The program words come in through a simple indexed fetch port: the block presents `prog_idx` and samples `prog_word`.

Each transaction goes out as a request-channel frame of 123 bits. The frame is cut into `PHIT_W`-bit beats, low-order bit first, and sent over a valid/ready link. The response-channel frame comes back the same way on a second valid/ready link. Only one transaction is ever in flight. Any mismatch or malformed response stops the sequence and raises a sticky error. A new `start` clears that error.

The controller is one state machine with six states:

- `S_IDLE`: waiting after reset.
- `S_ISSUE`: handing a frame to the serializer.
- `S_DRAIN`: the serializer is still shifting the frame out.
- `S_WAIT`: awaiting the matching response.
- `S_DONE`: the sequence finished.
- `S_FAIL`: the sequence stopped on an error.

The transitions are:

- `start` moves `S_IDLE`, `S_DONE` or `S_FAIL` to `S_ISSUE`.
- Handoff moves `S_ISSUE` to `S_DRAIN`.
- An empty serializer moves `S_DRAIN` to `S_WAIT`.
- A good response moves `S_WAIT` to `S_ISSUE`, or to `S_DONE` after the doorbell.
- A bad response moves `S_WAIT` to `S_FAIL`.

A step register selects the transaction type:

- `T_BOOT`: boot read.
- `T_WRITE`: scratchpad write.
- `T_READ`: scratchpad readback.
- `T_BELL`: doorbell write.

Top module: `sl_host_loader`

## Requirements
- R1: A `start` pulse in `S_IDLE`, `S_DONE` or `S_FAIL` begins a new sequence: `busy` rises and `err`/`done` clear on the next cycle. A `start` while `busy` is high is ignored, and the running sequence continues unchanged.
- R2: Every request frame carries these header fields:
  - channel id 0
  - param 0
  - size 2 (4 bytes)
  - source `SRC_ID`
  - corrupt 0
  - last 1
  - opcode 4 (Get) for reads, or opcode 0 (PutFullData) for writes
- R3: The 8-bit mask field and the 64-bit data field depend on address bit 2:
  - When bit 2 is 0, the mask is 0x0F and a write word sits in data bits [31:0].
  - When bit 2 is 1, the mask is 0xF0 and the word sits in data bits [63:32].
  - The other data half is zero, and a read carries all-zero data.
- R4: Frame bit layout, MSB to LSB: channel[122:120], opcode[119:117], param[116:114], size[113:110], source[109:106], address[105:74], data[73:10], corrupt[9], mask[8:1], last[0]. The frame is sent reversed: beat j carries frame bits [j*PHIT_W +: PHIT_W], and bits above 122 in the last beat are zero. `tx_bits` holds steady while `tx_valid` is high and `tx_ready` is low.
- R5: The request sequence is:
  1. Get at 0x0001_0000.
  2. For each word i from 0 to NWORDS-1: a PutFullData of `prog_word` for index i at 0x8000_0000+4i, followed by a Get at the same address.
  3. PutFullData of value 1 at 0x0200_0000.

  A successful run therefore issues 2*NWORDS+2 frames.
- R6: No request frame starts before the response to the previous request has been fully received.
- R7: If the boot read returns a word different from `boot_expect`, `err` is set and no further request is issued.
- R8: If a readback returns a word different from the one written, `err` is set and stays set until the next `start`. No further request is issued, and in particular no doorbell write.
- R9: A response is accepted only if all of the following hold; otherwise `err` is set and the sequence stops:
  - channel id is 3
  - opcode is 1 (AccessAckData) for a Get, or 0 (AccessAck) for a Put
  - param is 0, size is 2, source is `SRC_ID`, address is 0
  - corrupt is 0, mask/union is 0, last is 1
  - the unused data half is zero (all of the data for AccessAck)
  - the padding bits are zero
- R10: A response frame that completes while no response is awaited (`S_ISSUE` or `S_DRAIN`) is discarded, and the run still ends in `done`.
- R11: After the AccessAck to the doorbell write, `done` is high, `busy` is low and `err` is low.
- R12: Response frames use the same layout and beat order as R4: beat j on `rx_bits` fills frame bits [j*PHIT_W +: PHIT_W].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load sequence |
| boot_expect | input | 32 | Word expected from the boot memory read |
| prog_idx | output | $clog2(NWORDS) | Index of the program word being fetched |
| prog_word | input | 32 | Program word at `prog_idx` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed and doorbell acknowledged |
| err | output | 1 | Sticky failure flag |
| tx_valid | output | 1 | Request beat valid |
| tx_ready | input | 1 | Request beat accepted |
| tx_bits | output | PHIT_W | Request beat data |
| rx_valid | input | 1 | Response beat valid |
| rx_ready | output | 1 | Response beat accepted |
| rx_bits | input | PHIT_W | Response beat data |

## Verification
The deserializer can finish assembling a response frame during the same cycles in which the serializer is still shifting out a request. The controller must then tell a stray frame from the real reply. The bench provokes this by launching an unsolicited AccessAck on the response link at the exact cycle the first beat of the boot read leaves. It slows `tx_ready` so that the stray frame completes while the controller is still in `S_DRAIN`. The run is judged by the full frame sequence, the scratchpad contents and a clean `done` with `err` low. Further runs inject a wrong boot word, a wrong readback at every word index and a wrong response opcode, and each is judged by the exact number of frames issued before the stop.

// File: rtl/sl_loader_pkg.sv
package sl_loader_pkg;

    localparam int FRAME_W = 123;

    localparam logic [2:0] CH_REQ      = 3'd0;
    localparam logic [2:0] CH_RSP      = 3'd3;
    localparam logic [2:0] OP_GET      = 3'd4;
    localparam logic [2:0] OP_PUT_FULL = 3'd0;
    localparam logic [2:0] OP_ACK_DATA = 3'd1;
    localparam logic [2:0] OP_ACK      = 3'd0;
    localparam logic [3:0] SIZE_WORD   = 4'd2;

    // First member is the most significant; bit 0 is the last flag.
    typedef struct packed {
        logic [2:0]  chan;
        logic [2:0]  opcode;
        logic [2:0]  param;
        logic [3:0]  size;
        logic [3:0]  source;
        logic [31:0] addr;
        logic [63:0] data;
        logic        corrupt;
        logic [7:0]  lanes;
        logic        last;
    } link_frame_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_DRAIN,
        S_WAIT,
        S_DONE,
        S_FAIL
    } ld_state_t;

    typedef enum logic [1:0] {
        T_BOOT,
        T_WRITE,
        T_READ,
        T_BELL
    } ld_step_t;

    function automatic logic [63:0] place_word(input logic [31:0] w, input logic hi);
        return hi ? {w, 32'h0} : {32'h0, w};
    endfunction

endpackage

// File: rtl/sl_req_build.sv
module sl_req_build
    import sl_loader_pkg::*;
#(
    parameter int SRC_ID = 0
) (
    input  logic        is_put,
    input  logic [31:0] addr,
    input  logic [31:0] word,
    output link_frame_t frame
);

    logic hi;

    assign hi = addr[2];

    always_comb begin
        frame.chan    = CH_REQ;
        frame.opcode  = is_put ? OP_PUT_FULL : OP_GET;
        frame.param   = 3'd0;
        frame.size    = SIZE_WORD;
        frame.source  = 4'(SRC_ID);
        frame.addr    = addr;
        frame.data    = is_put ? place_word(word, hi) : 64'h0;
        frame.corrupt = 1'b0;
        frame.lanes   = hi ? 8'hF0 : 8'h0F;
        frame.last    = 1'b1;
    end

endmodule

// File: rtl/sl_rsp_check.sv
module sl_rsp_check
    import sl_loader_pkg::*;
#(
    parameter int PADW   = 124,
    parameter int SRC_ID = 0
) (
    input  logic [PADW-1:0] raw,
    input  logic            expect_data,
    input  logic            hi,
    output logic            ok,
    output logic [31:0]     rword
);

    link_frame_t got;
    link_frame_t want;
    logic        pad_ok;

    assign got   = raw[FRAME_W-1:0];
    assign rword = hi ? got.data[63:32] : got.data[31:0];

    generate
        if (PADW > FRAME_W) begin : g_pad
            assign pad_ok = ~|raw[PADW-1:FRAME_W];
        end else begin : g_nopad
            assign pad_ok = 1'b1;
        end
    endgenerate

    always_comb begin
        want.chan    = CH_RSP;
        want.opcode  = expect_data ? OP_ACK_DATA : OP_ACK;
        want.param   = 3'd0;
        want.size    = SIZE_WORD;
        want.source  = 4'(SRC_ID);
        want.addr    = 32'h0;
        want.data    = expect_data ? place_word(rword, hi) : 64'h0;
        want.corrupt = 1'b0;
        want.lanes   = 8'h0;
        want.last    = 1'b1;
    end

    assign ok = pad_ok && (got == want);

endmodule

// File: rtl/sl_link_ser.sv
module sl_link_ser #(
    parameter int W  = 4,
    parameter int FW = 123
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [FW-1:0] in_frame,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [W-1:0]  tx_bits
);

    localparam int NB   = (FW + W - 1) / W;
    localparam int PADW = NB * W;
    localparam int CW   = $clog2(NB + 1);

    logic [PADW-1:0] sh_q;
    logic [CW-1:0]   cnt_q;

    assign in_ready = (cnt_q == '0);
    assign tx_valid = (cnt_q != '0);
    assign tx_bits  = sh_q[W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (in_valid && in_ready) begin
            sh_q  <= PADW'(in_frame);
            cnt_q <= CW'(NB);
        end else if (tx_valid && tx_ready) begin
            sh_q  <= sh_q >> W;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R4: a stalled beat keeps its value
    p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_bits));

endmodule

// File: rtl/sl_link_des.sv
module sl_link_des #(
    parameter int W  = 4,
    parameter int FW = 123
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    output logic                                in_ready,
    input  logic [W-1:0]                        in_bits,
    output logic                                out_valid,
    input  logic                                out_ready,
    output logic [((FW + W - 1) / W) * W - 1:0] out_raw
);

    localparam int NB   = (FW + W - 1) / W;
    localparam int PADW = NB * W;
    localparam int CW   = $clog2(NB + 1);

    logic [PADW-1:0] sh_q;
    logic [CW-1:0]   cnt_q;
    logic            full_q;

    assign in_ready  = !full_q;
    assign out_valid = full_q;
    assign out_raw   = sh_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            full_q <= 1'b0;
        end else begin
            if (out_valid && out_ready) begin
                full_q <= 1'b0;
            end
            if (in_valid && in_ready) begin
                sh_q <= {in_bits, sh_q[PADW-1:W]};
                if (cnt_q == CW'(NB - 1)) begin
                    cnt_q  <= '0;
                    full_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R12: a frame completes only on an accepted beat
    p_frame_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));

endmodule

// File: rtl/sl_host_loader.sv
module sl_host_loader
    import sl_loader_pkg::*;
#(
    parameter int          PHIT_W       = 4,
    parameter int          NWORDS       = 4,
    parameter int          SRC_ID       = 0,
    parameter logic [31:0] BOOT_ADDR    = 32'h0001_0000,
    parameter logic [31:0] SCRATCH_BASE = 32'h8000_0000,
    parameter logic [31:0] BELL_ADDR    = 32'h0200_0000
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          start,
    input  logic [31:0]                                   boot_expect,
    output logic [((NWORDS > 1) ? $clog2(NWORDS) : 1)-1:0] prog_idx,
    input  logic [31:0]                                   prog_word,
    output logic                                          busy,
    output logic                                          done,
    output logic                                          err,
    output logic                                          tx_valid,
    input  logic                                          tx_ready,
    output logic [PHIT_W-1:0]                             tx_bits,
    input  logic                                          rx_valid,
    output logic                                          rx_ready,
    input  logic [PHIT_W-1:0]                             rx_bits
);

    localparam int IW   = (NWORDS > 1) ? $clog2(NWORDS) : 1;
    localparam int NB   = (FRAME_W + PHIT_W - 1) / PHIT_W;
    localparam int PADW = NB * PHIT_W;

    ld_state_t       state_q, state_d;
    ld_step_t        step_q, step_d;
    logic [IW-1:0]   idx_q, idx_d;
    logic            err_q, done_q;

    logic [31:0]     req_addr;
    logic [31:0]     req_word;
    logic            req_is_put;
    link_frame_t     req_frame;
    logic            ser_valid, ser_ready;
    logic            rsp_valid;
    logic [PADW-1:0] rsp_raw;
    logic            rsp_ok;
    logic [31:0]     rword;
    logic            want_cmp;
    logic [31:0]     cmp_word;
    logic            rsp_bad;

    // ---------------- request content ----------------
    always_comb begin
        unique case (step_q)
            T_BOOT:  req_addr = BOOT_ADDR;
            T_WRITE,
            T_READ:  req_addr = SCRATCH_BASE + (32'(idx_q) << 2);
            T_BELL:  req_addr = BELL_ADDR;
            default: req_addr = BOOT_ADDR;
        endcase
    end

    assign req_is_put = (step_q == T_WRITE) || (step_q == T_BELL);
    assign req_word   = (step_q == T_WRITE) ? prog_word :
                        (step_q == T_BELL)  ? 32'd1 : 32'd0;
    assign want_cmp   = (step_q == T_BOOT) || (step_q == T_READ);
    assign cmp_word   = (step_q == T_BOOT) ? boot_expect : prog_word;

    sl_req_build #(.SRC_ID(SRC_ID)) u_build (
        .is_put (req_is_put),
        .addr   (req_addr),
        .word   (req_word),
        .frame  (req_frame)
    );

    sl_link_ser #(.W(PHIT_W), .FW(FRAME_W)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (ser_valid),
        .in_ready (ser_ready),
        .in_frame (req_frame),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_bits  (tx_bits)
    );

    sl_link_des #(.W(PHIT_W), .FW(FRAME_W)) u_des (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_valid),
        .in_ready  (rx_ready),
        .in_bits   (rx_bits),
        .out_valid (rsp_valid),
        .out_ready (1'b1),
        .out_raw   (rsp_raw)
    );

    sl_rsp_check #(.PADW(PADW), .SRC_ID(SRC_ID)) u_chk (
        .raw         (rsp_raw),
        .expect_data (want_cmp),
        .hi          (req_addr[2]),
        .ok          (rsp_ok),
        .rword       (rword)
    );

    assign rsp_bad = !rsp_ok || (want_cmp && (rword != cmp_word));

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        idx_d   = idx_q;
        unique case (state_q)
            S_IDLE, S_DONE, S_FAIL: begin
                if (start) begin
                    state_d = S_ISSUE;
                    step_d  = T_BOOT;
                    idx_d   = '0;
                end
            end
            S_ISSUE: begin
                if (ser_ready) begin
                    state_d = S_DRAIN;
                end
            end
            S_DRAIN: begin
                if (ser_ready) begin
                    state_d = S_WAIT;
                end
            end
            S_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_bad) begin
                        state_d = S_FAIL;
                    end else begin
                        state_d = S_ISSUE;
                        unique case (step_q)
                            T_BOOT:  step_d = T_WRITE;
                            T_WRITE: step_d = T_READ;
                            T_READ: begin
                                if (idx_q == IW'(NWORDS - 1)) begin
                                    step_d = T_BELL;
                                end else begin
                                    step_d = T_WRITE;
                                    idx_d  = idx_q + 1'b1;
                                end
                            end
                            T_BELL:  state_d = S_DONE;
                            default: state_d = S_FAIL;
                        endcase
                    end
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= T_BOOT;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            idx_q   <= idx_d;
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            err_q  <= (state_d == S_FAIL);
            done_q <= (state_d == S_DONE);
        end
    end

    assign ser_valid = (state_q == S_ISSUE);
    assign busy      = (state_q == S_ISSUE) || (state_q == S_DRAIN) || (state_q == S_WAIT);
    assign done      = done_q;
    assign err       = err_q;
    assign prog_idx  = idx_q;

    // R6: nothing is sent while a reply is awaited
    p_wait_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_WAIT |-> !tx_valid);

    // R8: the error flag holds until a new start
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q && !start |=> err_q);

    // R11: completion never coexists with an error
    p_done_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !err_q);

    // R10: a frame landing outside S_WAIT causes no error
    p_stray_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (state_q inside {S_ISSUE, S_DRAIN}) |=> !err_q);

endmodule

// File: tb/sl_host_loader_bench.sv
`timescale 1ns/1ps
module sl_host_loader_bench;

    localparam int          W    = 4;
    localparam int          NW   = 4;
    localparam int          IW   = 2;
    localparam int          FW   = 123;
    localparam int          NB   = (FW + W - 1) / W;
    localparam int          PADW = NB * W;
    localparam logic [31:0] BOOT_VAL = 32'h1357_2468;
    localparam logic [31:0] SCR      = 32'h8000_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [31:0]   boot_expect = BOOT_VAL;
    logic [IW-1:0] prog_idx;
    logic [31:0]   prog_word = '0;
    logic          busy, done, err;
    logic          tx_valid;
    logic          tx_ready = 1'b0;
    logic [W-1:0]  tx_bits;
    logic          rx_valid = 1'b0;
    logic          rx_ready;
    logic [W-1:0]  rx_bits = '0;

    always #4 clk = ~clk;

    sl_host_loader u_sl_host_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .boot_expect (boot_expect),
        .prog_idx    (prog_idx),
        .prog_word   (prog_word),
        .busy        (busy),
        .done        (done),
        .err         (err),
        .tx_valid    (tx_valid),
        .tx_ready    (tx_ready),
        .tx_bits     (tx_bits),
        .rx_valid    (rx_valid),
        .rx_ready    (rx_ready),
        .rx_bits     (rx_bits)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [31:0]     key_q;
    bit              stray_mode, stray_sent;
    int              fault_word, bad_op_word;
    bit              boot_wrong;
    int              nframes;
    bit              bell;
    logic [31:0]     mem [NW];
    logic [PADW-1:0] cap;
    int              cbeats = 0;
    logic [PADW-1:0] rsp, rnext;
    int              rbeats = 0;
    bit              ractive = 0, rpend = 0, ris_real = 0, awaiting = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pword(input int i);
        return key_q ^ (32'(i) * 32'h0193_5A6B) ^ 32'h5A00_00A5;
    endfunction

    function automatic logic [PADW-1:0] mk_rsp(input logic [2:0] op, input logic hi,
                                               input logic [31:0] w);
        logic [PADW-1:0] f;
        f = '0;
        f[122:120] = 3'd3;
        f[119:117] = op;
        f[113:110] = 4'd2;
        f[109:106] = 4'd0;
        if (op == 3'd1) f[73:10] = hi ? {w, 32'h0} : {32'h0, w};
        f[0] = 1'b1;
        return f;
    endfunction

    task automatic handle_frame();
        logic [2:0]  chan, opc, prm;
        logic [3:0]  sz, src;
        logic [31:0] adr, ew, rv;
        logic [63:0] dat, edat;
        logic [7:0]  msk;
        bit          eput, known;
        logic [31:0] eadr;
        int          e, wi;
        chan = cap[122:120]; opc = cap[119:117]; prm = cap[116:114];
        sz = cap[113:110]; src = cap[109:106]; adr = cap[105:74];
        dat = cap[73:10]; msk = cap[8:1];
        e = nframes;
        known = 1; eput = 0; eadr = 32'h0; ew = 32'h0; wi = 0;
        if (e == 0) begin
            eadr = 32'h0001_0000;
        end else if (e <= 2 * NW) begin
            wi = (e - 1) / 2;
            eput = ((e - 1) % 2) == 0;
            eadr = SCR + 32'(wi * 4);
            ew = eput ? pword(wi) : 32'h0;
        end else if (e == 2 * NW + 1) begin
            eput = 1; eadr = 32'h0200_0000; ew = 32'd1;
        end else begin
            known = 0;
        end
        chk(known, "R5", "frame beyond end of sequence", 64'(e), 64'(2 * NW + 1));
        if (known) begin
            chk(chan == 3'd0, "R2", "channel id", 64'(chan), 0);
            chk(opc == (eput ? 3'd0 : 3'd4), "R2", "opcode", 64'(opc), eput ? 0 : 4);
            chk(prm == 0 && sz == 4'd2 && src == 0 && cap[9] == 0 && cap[0] == 1,
                "R2", "param/size/source/corrupt/last", {prm, sz, src, cap[9], cap[0]},
                {3'd0, 4'd2, 4'd0, 1'b0, 1'b1});
            chk(adr == eadr, "R5", "address order", 64'(adr), 64'(eadr));
            chk(msk == (eadr[2] ? 8'hF0 : 8'h0F), "R3", "mask", 64'(msk),
                eadr[2] ? 64'hF0 : 64'h0F);
            edat = eadr[2] ? {ew, 32'h0} : {32'h0, ew};
            chk(dat == edat, "R3", "data placement", dat, edat);
            chk(cap[PADW-1:FW] == '0, "R4", "padding bits", 64'(cap[PADW-1:FW]), 0);
        end
        nframes++;
        if (!eput) begin
            if (adr == 32'h0001_0000) rv = boot_wrong ? (BOOT_VAL ^ 32'h8000_0001) : BOOT_VAL;
            else rv = mem[wi] ^ ((fault_word == wi) ? 32'h0000_0100 : 32'h0);
            rnext = mk_rsp(3'd1, adr[2], rv);
        end else begin
            if (adr == 32'h0200_0000) bell = 1;
            else mem[wi] = dat[adr[2] ? 63 : 31 -: 32];
            rnext = (bad_op_word == wi && adr != 32'h0200_0000) ? mk_rsp(3'd1, adr[2], 32'h0)
                                                                 : mk_rsp(3'd0, 1'b0, 32'h0);
        end
        rpend = 1;
        awaiting = 1;
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        prog_word = pword(int'(prog_idx));
        tx_ready  = stray_mode ? cyc[0] : ((cyc % 5) != 3);
        if (tx_valid && tx_ready) begin
            if (cbeats == 0) begin
                chk(!awaiting, "R6", "request begun before response", 64'(awaiting), 0);
                if (stray_mode && !stray_sent && !ractive) begin
                    rsp = mk_rsp(3'd0, 1'b0, 32'h0);
                    ractive = 1; rbeats = 0; ris_real = 0; stray_sent = 1;
                end
            end
            cap[cbeats*W +: W] = tx_bits;
            cbeats++;
            if (cbeats == NB) begin
                handle_frame();
                cbeats = 0;
            end
        end
        if (!ractive && rpend) begin
            rsp = rnext; ractive = 1; rbeats = 0; rpend = 0; ris_real = 1;
        end
        if (ractive) begin
            rx_valid = (cyc % 7) != 2;
            rx_bits  = rsp[rbeats*W +: W];
            if (rx_valid && rx_ready) begin
                rbeats++;
                if (rbeats == NB) begin
                    ractive = 0;
                    if (ris_real) awaiting = 0;
                end
            end
        end else begin
            rx_valid = 1'b0;
            rx_bits  = '0;
        end
    endtask

    task automatic run_case(input logic [31:0] key, input bit strayq, input int faultw,
                            input int badop, input bit bootbad, input bit mid_start);
        int    exp_frames;
        bit    exp_ok;
        string rq;
        key_q = key; stray_mode = strayq; stray_sent = 0;
        fault_word = faultw; bad_op_word = badop; boot_wrong = bootbad;
        nframes = 0; bell = 0;
        for (int i = 0; i < NW; i++) mem[i] = 32'h0;
        start = 1'b1;
        step();
        start = 1'b0;
        step();
        chk(busy == 1'b1, "R1", "busy after start", 64'(busy), 1);
        chk(err == 1'b0 && done == 1'b0, "R1", "flags cleared by start", {err, done}, 0);
        for (int n = 0; n < 20000; n++) begin
            if ((done || err) && !ractive && !rpend) break;
            if (mid_start && n == 150) begin
                chk(busy == 1'b1, "R1", "busy when extra start is sent", 64'(busy), 1);
                start = 1'b1;
            end
            step();
            start = 1'b0;
        end
        repeat (300) step();
        exp_ok = !(bootbad || faultw >= 0 || badop >= 0);
        exp_frames = bootbad ? 1 : (faultw >= 0) ? 2 * faultw + 3 :
                     (badop >= 0) ? 2 * badop + 2 : 2 * NW + 2;
        rq = bootbad ? "R7" : (faultw >= 0) ? "R8" : (badop >= 0) ? "R9" : "R11";
        chk(nframes == exp_frames, rq, "frames issued", 64'(nframes), 64'(exp_frames));
        chk(done == exp_ok, rq, "done flag", 64'(done), 64'(exp_ok));
        chk(err == !exp_ok, rq, "error flag", 64'(err), 64'(!exp_ok));
        chk(busy == 1'b0, rq, "busy at end", 64'(busy), 0);
        chk(bell == exp_ok, "R8", "doorbell written", 64'(bell), 64'(exp_ok));
        if (exp_ok) begin
            for (int i = 0; i < NW; i++)
                chk(mem[i] == pword(i), "R5", "scratchpad word", 64'(mem[i]), 64'(pword(i)));
            chk(done, "R12", "responses parsed from beats", 64'(done), 1);
            if (mid_start) chk(nframes == 2 * NW + 2, "R1", "start while busy ignored",
                               64'(nframes), 64'(2 * NW + 2));
        end
        if (strayq) chk(stray_sent && done && !err, "R10", "stray response discarded",
                        {stray_sent, done, err}, 3'b110);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        fault_word = -1; bad_op_word = -1; boot_wrong = 0;
        stray_mode = 0; key_q = 32'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err, "R1", "reset flags", {busy, done, err}, 0);
        chk(!tx_valid && rx_ready, "R4", "reset link state", {tx_valid, rx_ready}, 2'b01);
        run_case(32'hC0DE_0001, 0, -1, -1, 0, 1);
        run_case(32'h0BAD_F00D, 1, -1, -1, 0, 0);
        run_case(32'h1111_2222, 0, -1, -1, 1, 0);
        for (int k = 0; k < NW; k++) run_case(32'h3C3C_0000 + 32'(k), 0, k, -1, 0, 0);
        run_case(32'h7777_0707, 0, -1, 1, 0, 0);
        run_case(32'hFFFF_0000, 0, -1, -1, 0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule